// File: doc/BRIEF.md
# Memory Bit Invert Sequencer

This block flips a single bit of one byte held in a synchronous byte-wide memory and reports what that bit held before the flip. A caller presents a base address, a 16-bit displacement, a 3-bit immediate bit index and a register value, and pulses `start`. A form select chooses how these are used. In displacement form the target address is the base plus the sign-extended displacement and the bit index is the immediate. In register form the address is the base alone and the bit index is the low three bits of the register value.

The sequence takes three cycles after the accepting edge. In the first cycle a read is issued. In the second cycle the returned byte is captured. In the third cycle the byte is written back with only the chosen bit inverted, and `done` pulses. The zero flag comes out as the logical inverse of the original bit. It keeps that value until the next operation completes.

Top module: `bit_flip_seq`

## Requirements
- R1: In displacement form (`use_reg_form`=0) `mem_addr` equals `base_addr` plus `disp` sign-extended to the address width, with wrap-around.
- R2: In register form (`use_reg_form`=1) `mem_addr` equals `base_addr` and `disp` has no effect.
- R3: The bit index is `bit_imm` in displacement form. In register form it is `bit_reg[2:0]`, and the upper bits of `bit_reg` have no effect. Index 0 is the least significant bit of the byte.
- R4: When the operation completes, `zflag` equals the inverse of the addressed bit as read from memory (1 when that bit was 0).
- R5: The byte written back equals the byte read with only the addressed bit inverted. After the operation the memory byte has exactly that value.
- R6: After an accepting edge, `mem_rd` is high for exactly the first cycle. `mem_wr` and `done` are high together for exactly the third cycle, and `busy` is high for all three cycles.
- R7: `mem_rd` and `mem_wr` are never high in the same cycle. A write only follows a read two cycles earlier.
- R8: `start` is accepted only while `busy` is low. A `start` during an operation is ignored: no extra read or write occurs and the address does not change.
- R9: After a synchronous reset `busy`, `done`, `mem_rd`, `mem_wr` and `zflag` are all 0.
- R10: `zflag` changes only in a cycle in which `done` is high. Between operations it holds its value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled when idle |
| use_reg_form | input | 1 | 0: base+displacement with immediate bit index; 1: base only with register bit index |
| base_addr | input | ADDR_W | Base address |
| disp | input | DISP_W | Signed displacement |
| bit_imm | input | 3 | Immediate bit index |
| bit_reg | input | REG_W | Register holding the bit index in its low bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zflag | output | 1 | Inverse of the original bit value |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
The embedded assertions check on every cycle that:
- reads and writes never overlap;
- every write trails a read by two cycles;
- a read pulse lasts one cycle and never starts while busy;
- the flag moves only with `done`;
- the written byte differs from the captured byte in exactly one position.

The bench's scenarios are needed to show which bit is flipped, because that depends on the form select, the immediate and the register. They are also needed to show the address arithmetic, including negative and extreme displacements, the final memory contents and the exact cycle of each strobe. Both are compared against a model of the memory kept in the bench.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_MODW = 2'd2,
    ST_DONE = 2'd3
  } bfs_state_e;
endpackage

// File: rtl/bfs_addr_gen.sv
module bfs_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int REG_W  = 32,
  parameter int BSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              use_reg_form,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic [BSEL_W-1:0] bit_imm,
  input  logic [REG_W-1:0]  bit_reg,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BSEL_W-1:0] bsel_q
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] addr_next;
  logic [BSEL_W-1:0] bsel_next;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

  always_comb begin
    if (use_reg_form) begin
      addr_next = base_addr;
      bsel_next = bit_reg[BSEL_W-1:0];
    end else begin
      addr_next = base_addr + disp_ext;
      bsel_next = bit_imm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      bsel_q <= '0;
    end else if (load) begin
      addr_q <= addr_next;
      bsel_q <= bsel_next;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(addr_q)) else $error("address moved without load"); // R8
endmodule

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import bfs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic capture,
  output logic busy,
  output logic mem_rd_q,
  output logic mem_wr_q,
  output logic done_q
);
  bfs_state_e state, state_nx;

  assign load    = (state == ST_IDLE) && start;
  assign capture = (state == ST_MODW);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start) state_nx = ST_READ;
      ST_READ: state_nx = ST_MODW;
      ST_MODW: state_nx = ST_DONE;
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_rd_q <= 1'b0;
      mem_wr_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state    <= state_nx;
      mem_rd_q <= load;
      mem_wr_q <= capture;
      done_q   <= capture;
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_q && mem_wr_q)) else $error("read and write overlap"); // R7
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    mem_wr_q |-> $past(mem_rd_q, 2)) else $error("write without prior read"); // R7
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_q |=> !mem_rd_q) else $error("read strobe too long"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q) else $error("done too long"); // R6
endmodule

// File: rtl/bfs_bit_modify.sv
module bfs_bit_modify #(
  parameter int DATA_W = 8,
  parameter int BSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [BSEL_W-1:0] bsel,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata_q,
  output logic              zflag_q
);
  logic [DATA_W-1:0] flipped;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign flipped[i] = rdata[i] ^ (bsel == BSEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q <= '0;
      zflag_q <= 1'b0;
    end else if (capture) begin
      wdata_q <= flipped;
      zflag_q <= ~rdata[bsel];
    end
  end

  AST_ONE_BIT_FLIP: assert property (@(posedge clk) disable iff (rst)
    capture |=> ($countones(wdata_q ^ $past(rdata)) == 1)) else $error("flip count wrong"); // R5
  AST_Z_VS_WDATA: assert property (@(posedge clk) disable iff (rst)
    capture |=> (zflag_q == wdata_q[$past(bsel)])) else $error("flag disagrees with written bit"); // R4
endmodule

// File: rtl/bit_flip_seq.sv
module bit_flip_seq #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int REG_W  = 32,
  parameter int DATA_W = 8,
  localparam int BSEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              use_reg_form,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic [BSEL_W-1:0] bit_imm,
  input  logic [REG_W-1:0]  bit_reg,
  output logic              busy,
  output logic              done,
  output logic              zflag,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              load;
  logic              capture;
  logic [BSEL_W-1:0] bsel;

  bfs_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .load     (load),
    .capture  (capture),
    .busy     (busy),
    .mem_rd_q (mem_rd),
    .mem_wr_q (mem_wr),
    .done_q   (done)
  );

  bfs_addr_gen #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .REG_W  (REG_W),
    .BSEL_W (BSEL_W)
  ) u_addr (
    .clk          (clk),
    .rst          (rst),
    .load         (load),
    .use_reg_form (use_reg_form),
    .base_addr    (base_addr),
    .disp         (disp),
    .bit_imm      (bit_imm),
    .bit_reg      (bit_reg),
    .addr_q       (mem_addr),
    .bsel_q       (bsel)
  );

  bfs_bit_modify #(
    .DATA_W (DATA_W),
    .BSEL_W (BSEL_W)
  ) u_mod (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .bsel    (bsel),
    .rdata   (mem_rdata),
    .wdata_q (mem_wdata),
    .zflag_q (zflag)
  );

  AST_Z_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(zflag) |-> done) else $error("flag moved outside done"); // R10
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !$past(busy)) else $error("read launched while busy"); // R8
  AST_DONE_WITH_WR: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_wr && busy)) else $error("done without write"); // R6
endmodule

// File: tb/bit_flip_seq_tb.sv
module bit_flip_seq_tb;
  localparam int NV = 8;
  localparam logic        V_FORM [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] V_BASE [NV] = '{32'h100, 32'h200, 32'h5, 32'h340, 32'h3C1, 32'hFF, 32'h7F, 32'h50};
  localparam logic [15:0] V_DISP [NV] = '{16'h0010, 16'hFFFE, 16'h8000, 16'h1234, 16'h7FFF, 16'h7FFF, 16'h0040, 16'h0000};
  localparam logic [2:0]  V_BIMM [NV] = '{3'd1, 3'd0, 3'd7, 3'd0, 3'd7, 3'd6, 3'd3, 3'd4};
  localparam logic [31:0] V_BREG [NV] = '{32'hFFFFFFF0, 32'h0, 32'h0, 32'h000000FD, 32'h80000002, 32'h3, 32'h7, 32'h0};
  localparam logic [7:0]  V_INIT [NV] = '{8'h08, 8'h00, 8'h7F, 8'hFF, 8'h5A, 8'h40, 8'h80, 8'hEF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic use_reg_form = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] disp = '0;
  logic [2:0]  bit_imm = '0;
  logic [31:0] bit_reg = '0;
  logic busy, done, zflag, mem_rd, mem_wr;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0] mem [256];
  logic       pl_en = 1'b0;
  logic [7:0] pl_addr = '0;
  logic [7:0] pl_data = '0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (pl_en) mem[pl_addr] <= pl_data;
    else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  bit_flip_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .use_reg_form(use_reg_form),
    .base_addr(base_addr), .disp(disp), .bit_imm(bit_imm), .bit_reg(bit_reg),
    .busy(busy), .done(done), .zflag(zflag), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic run_vec(input logic form, input logic [31:0] base, input logic [15:0] dsp,
                         input logic [2:0] bimm, input logic [31:0] breg, input logic [7:0] init);
    logic [31:0] ea;
    logic [2:0]  b;
    logic [7:0]  expb;
    ea   = form ? base : base + {{16{dsp[15]}}, dsp};
    b    = form ? breg[2:0] : bimm;
    expb = init ^ (8'h1 << b);
    preload(ea[7:0], init);
    preload(ea[7:0] + 8'd1, 8'hA5);
    @(negedge clk);
    start = 1'b1; use_reg_form = form; base_addr = base; disp = dsp; bit_imm = bimm; bit_reg = breg;
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd && !mem_wr && busy, "R6 read in first cycle", {29'd0, mem_rd, mem_wr, busy}, 32'h5);
    chk(mem_addr == ea, form ? "R2 register-form address" : "R1 displacement address", mem_addr, ea);
    @(negedge clk);
    chk(!mem_rd && !mem_wr && !done, "R7 no strobe in second cycle", {29'd0, mem_rd, mem_wr, done}, 32'h0);
    @(negedge clk);
    chk(done && mem_wr, "R6 done with write in third cycle", {30'd0, done, mem_wr}, 32'h3);
    chk(mem_wdata == expb, "R5 R3 write data", {24'd0, mem_wdata}, {24'd0, expb});
    chk(zflag == ~init[b], "R4 zero flag", {31'd0, zflag}, {31'd0, ~init[b]});
    @(negedge clk);
    chk(!done && !busy && !mem_wr, "R6 back to idle", {29'd0, done, busy, mem_wr}, 32'h0);
    chk(mem[ea[7:0]] == expb && mem[ea[7:0] + 8'd1] == 8'hA5, "R5 memory contents",
        {16'd0, mem[ea[7:0]], mem[ea[7:0] + 8'd1]}, {16'd0, expb, 8'hA5});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int rd_cnt;
    int wr_cnt;
    logic zsave;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr && !zflag, "R9 reset state",
        {27'd0, busy, done, mem_rd, mem_wr, zflag}, 32'h0);

    for (int i = 0; i < NV; i++)
      run_vec(V_FORM[i], V_BASE[i], V_DISP[i], V_BIMM[i], V_BREG[i], V_INIT[i]);

    // R8: start held high through an operation triggers one access only
    preload(8'h20, 8'h00);
    preload(8'h90, 8'h3C);
    @(negedge clk);
    start = 1'b1; use_reg_form = 1'b1; base_addr = 32'h20; bit_reg = 32'h0;
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    base_addr = 32'h90; bit_reg = 32'h5;
    for (int c = 0; c < 2; c++) begin
      rd_cnt += mem_rd; wr_cnt += mem_wr;
      chk(mem_addr == 32'h20, "R8 address unchanged while busy", mem_addr, 32'h20);
      @(negedge clk);
    end
    rd_cnt += mem_rd; wr_cnt += mem_wr;
    start = 1'b0;
    @(negedge clk);
    rd_cnt += mem_rd; wr_cnt += mem_wr;
    chk(rd_cnt == 1 && wr_cnt == 1, "R8 one read and one write", {16'(rd_cnt), 16'(wr_cnt)}, 32'h00010001);
    chk(mem[8'h20] == 8'h01 && mem[8'h90] == 8'h3C, "R8 ignored start leaves memory",
        {16'd0, mem[8'h20], mem[8'h90]}, 32'h0000013C);

    // R10: flag holds while idle inputs move
    zsave = zflag;
    for (int c = 0; c < 6; c++) begin
      use_reg_form = c[0]; bit_imm = 3'(c); bit_reg = 32'(c * 3); base_addr = 32'(c);
      @(negedge clk);
    end
    chk(zflag == zsave && !mem_rd && !busy, "R10 flag holds while idle",
        {30'd0, zflag, mem_rd}, {30'd0, zsave, 1'b0});

    // R4 R10: flag goes the other way on a second flip of the same bit
    run_vec(1'b1, 32'h20, 16'h0, 3'd0, 32'h0, 8'h01);
    chk(zflag == 1'b0, "R10 flag updated only by completion", {31'd0, zflag}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule